// File: doc/BRIEF.md
# Horizontal Pixel Clock Generator

This block produces the fast-direction (column) clocks for one quadrant of a raster-scanned infrared readout multiplexer. A single-cycle start request launches one line. The block raises the line-sync output, which releases the on-array horizontal shift register. It then toggles a pair of complementary pixel phases, with one full phase cycle per pixel, and finally parks the phases low and drops line-sync. Two mirrored copies of the phases are driven so that all four array clock pins can be wired straight from the block.

A downstream sampler follows the line through a one-cycle pixel strobe and a pixel index. A reference flag marks the extra slot that comes after the last active column. In that slot the array presents its zero-signal reference. The half-period of the phases and the number of overclock pixels are programmable. Both are captured when a line starts, so changing them during a line takes effect only on the next line.

Top module: `hpix_clkgen`

## Requirements
- R1: After a start request accepted in idle, line-sync is high and phase A is low for exactly one half-period before the first pixel begins.
- R2: Every pixel is phase A high for one half-period of system clocks followed by phase A low for one half-period.
- R3: Phase B is always the complement of phase A. Mirror A always equals phase A, and mirror B always equals phase B.
- R4: Line-sync falls only in a cycle that follows a cycle with phase A low. Outside a line, line-sync and phase A are both low.
- R5: A line contains ACTIVE_PIX + max(extra_pix, 1) pixels. The index reads 0 for the first pixel and rises by one per pixel.
- R6: The reference flag is high for exactly the pixel whose index equals ACTIVE_PIX, for its whole duration, and for no other pixel.
- R7: The pixel strobe is high for one system clock per pixel, at cycle floor(H/2) (counting from 0) of the pixel's low half-period.
- R8: The effective half-period H is max(half_period, 2).
- R9: In the cycle after the last pixel's low half ends, line-sync is low and line-done is high for exactly one cycle. The block is then idle.
- R10: A start request is ignored while a line is in progress, including the line-done cycle. Changes to half_period and extra_pix during a line do not affect that line.
- R11: After reset, line-sync, phase A, strobe, reference flag and line-done are all low, and phase B is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start-of-line request, sampled in idle only |
| half_period | input | CNT_W | System clocks per phase half, clamped to at least 2 |
| extra_pix | input | PIX_W | Overclock pixels after the active columns, treated as at least 1 |
| line_sync | output | 1 | High while the horizontal register is released |
| phase_a | output | 1 | Pixel phase A |
| phase_b | output | 1 | Pixel phase B, complement of phase A |
| phase_a_mir | output | 1 | Mirror copy of phase A |
| phase_b_mir | output | 1 | Mirror copy of phase B |
| pix_strobe | output | 1 | One-cycle pulse marking the sampling point of each pixel |
| pix_idx | output | PIX_W | Index of the current pixel |
| ref_flag | output | 1 | High during the reference pixel |
| line_done | output | 1 | One-cycle pulse ending the line |

## Verification
The end of the last pixel's low half and a fresh start request can fall in the same cycle. A start request can also coincide with the line-done cycle itself. The bench provokes both by raising start, together with a different half-period, exactly in the last running cycle in one pass and in the line-done cycle in another. Across a sweep of half-periods and overclock counts, it then checks every following cycle against the arithmetic schedule: line-done is a single pulse, the block falls idle, and no new line-sync rises.

// File: rtl/hpix_pkg.sv
// Package: shared state encoding for the horizontal pixel clock generator.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package hpix_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } hpix_state_e;
endpackage

// File: rtl/hpix_halftimer.sv
// Half-period timer: counts system clocks inside one phase half and flags
// the last cycle and the sampling midpoint. Assumes limit >= 2 while run is high.
module hpix_halftimer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             end_tick,
    output logic             mid_tick
);
    logic [CNT_W-1:0] cnt_q;

    assign end_tick = run && (cnt_q == limit - 1'b1);
    assign mid_tick = run && (cnt_q == {1'b0, limit[CNT_W-1:1]});

    // Count up while running, wrap at the end of the half, hold zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || end_tick) cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
    end

    // R8: the counter never passes the programmed limit while running.
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < limit));
endmodule

// File: rtl/hpix_pixcounter.sv
// Pixel counter: holds the current pixel index, reports the last pixel of the
// line and the reference slot. Assumes last_idx >= ref index.
module hpix_pixcounter #(
    parameter int PIX_W      = 12,
    parameter int ACTIVE_PIX = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             adv,
    input  logic [PIX_W-1:0] last_idx,
    output logic [PIX_W-1:0] idx,
    output logic             is_last,
    output logic             is_ref
);
    localparam logic [PIX_W-1:0] REF_IDX = PIX_W'(ACTIVE_PIX);

    logic [PIX_W-1:0] idx_q;

    assign idx     = idx_q;
    assign is_last = (idx_q == last_idx);
    assign is_ref  = (idx_q == REF_IDX);

    // Reset to zero at line start, step by one at each pixel boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) idx_q <= '0;
        else if (adv)        idx_q <= idx_q + 1'b1;
    end

    // R5: the index only ever moves up by one.
    a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n || clear)
        adv |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/hpix_clkgen.sv
// Horizontal pixel clock generator for one quadrant. Sequences line-sync,
// two complementary phases with mirrors, a per-pixel strobe, pixel index,
// reference-slot flag and a line-done pulse. Settings are latched at start.
// Assumes ACTIVE_PIX + extra_pix fits in PIX_W bits.
module hpix_clkgen
    import hpix_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int PIX_W      = 12,
    parameter int ACTIVE_PIX = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] half_period,
    input  logic [PIX_W-1:0] extra_pix,
    output logic             line_sync,
    output logic             phase_a,
    output logic             phase_b,
    output logic             phase_a_mir,
    output logic             phase_b_mir,
    output logic             pix_strobe,
    output logic [PIX_W-1:0] pix_idx,
    output logic             ref_flag,
    output logic             line_done
);
    localparam logic [CNT_W-1:0] MIN_HALF  = CNT_W'(2);
    localparam logic [PIX_W-1:0] LAST_BASE = PIX_W'(ACTIVE_PIX - 1);

    hpix_state_e      st_q;
    logic             low_half_q;
    logic [CNT_W-1:0] h_lat_q;
    logic [PIX_W-1:0] last_lat_q;
    logic             run, end_tick, mid_tick;
    logic             is_last, is_ref, pix_adv, accept;

    assign run     = (st_q == ST_LEAD) || (st_q == ST_RUN);
    assign accept  = (st_q == ST_IDLE) && start;
    assign pix_adv = (st_q == ST_RUN) && low_half_q && end_tick && !is_last;

    hpix_halftimer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .limit(h_lat_q),
        .end_tick(end_tick), .mid_tick(mid_tick)
    );

    hpix_pixcounter #(.PIX_W(PIX_W), .ACTIVE_PIX(ACTIVE_PIX)) u_pix (
        .clk(clk), .rst_n(rst_n), .clear(accept), .adv(pix_adv),
        .last_idx(last_lat_q), .idx(pix_idx), .is_last(is_last), .is_ref(is_ref)
    );

    // Capture clamped half-period and last pixel index when a line is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_lat_q    <= MIN_HALF;
            last_lat_q <= LAST_BASE + 1'b1;
        end else if (accept) begin
            h_lat_q    <= (half_period < MIN_HALF) ? MIN_HALF : half_period;
            last_lat_q <= LAST_BASE + ((extra_pix == '0) ? PIX_W'(1) : extra_pix);
        end
    end

    // Line sequencer: idle, lead-in half, pixel halves, done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            low_half_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: if (start) st_q <= ST_LEAD;
                ST_LEAD: if (end_tick) begin
                    st_q       <= ST_RUN;
                    low_half_q <= 1'b0;
                end
                ST_RUN: if (end_tick) begin
                    low_half_q <= !low_half_q;
                    if (low_half_q && is_last) st_q <= ST_DONE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode from registered state.
    always_comb begin
        line_sync  = run;
        phase_a    = (st_q == ST_RUN) && !low_half_q;
        pix_strobe = (st_q == ST_RUN) && low_half_q && mid_tick;
        ref_flag   = (st_q == ST_RUN) && is_ref;
        line_done  = (st_q == ST_DONE);
    end

    // Mirrored phase copies for the second pair of array clock pins.
    assign phase_b     = !phase_a;
    assign phase_a_mir = phase_a;
    assign phase_b_mir = phase_b;

    // R4: line-sync may fall only after phase A has been low.
    a_r4_sync_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_sync) |-> !$past(phase_a));
    // R9: line-done is a single-cycle pulse, followed by idle.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> (!line_done && !line_sync));
    // R10: latched settings stay put while a line is running.
    a_r10_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> ($stable(h_lat_q) && $stable(last_lat_q)));
    // R7: the strobe only ever appears in the low half of a pixel.
    a_r7_strobe_low: assert property (@(posedge clk) disable iff (!rst_n)
        pix_strobe |-> (!phase_a && line_sync));
    // R8: the effective half-period is never below two.
    a_r8_min_half: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (h_lat_q >= MIN_HALF));
endmodule

// File: tb/tb_hpix_clkgen.sv
// Bench: sweeps half-period and overclock settings on a small quadrant and
// compares every cycle of each line against an arithmetic schedule.
module tb_hpix_clkgen;
    localparam int CNT_W = 4;
    localparam int PIX_W = 5;
    localparam int ACT   = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] half_period = '0;
    logic [PIX_W-1:0] extra_pix = '0;
    logic line_sync, phase_a, phase_b, phase_a_mir, phase_b_mir;
    logic pix_strobe, ref_flag, line_done;
    logic [PIX_W-1:0] pix_idx;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    hpix_clkgen #(.CNT_W(CNT_W), .PIX_W(PIX_W), .ACTIVE_PIX(ACT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .half_period(half_period),
        .extra_pix(extra_pix), .line_sync(line_sync), .phase_a(phase_a),
        .phase_b(phase_b), .phase_a_mir(phase_a_mir), .phase_b_mir(phase_b_mir),
        .pix_strobe(pix_strobe), .pix_idx(pix_idx), .ref_flag(ref_flag),
        .line_done(line_done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Runs one line; glitch_t >= 0 raises start with a new half-period in that cycle.
    task automatic run_line(input int h, input int x, input int glitch_t);
        int he, tot, d;
        he  = (h < 2) ? 2 : h;                        // R8
        tot = ACT + ((x < 1) ? 1 : x);                // R5
        d   = he + 2 * he * tot;
        @(negedge clk);
        half_period = CNT_W'(h);
        extra_pix   = PIX_W'(x);
        start       = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t <= d + 3; t++) begin
            int u, p, r;
            bit e_sync, e_pa, e_stb, e_ref, e_done;
            e_sync = (t < d); e_pa = 0; e_stb = 0; e_ref = 0; e_done = (t == d);
            p = 0;
            if (t >= he && t < d) begin
                u = t - he; p = u / (2 * he); r = u % (2 * he);
                e_pa  = (r < he);                     // R2
                e_stb = (r == he + he / 2);           // R7
                e_ref = (p == ACT);                   // R6
            end
            check("R1/R4 line_sync", int'(line_sync), int'(e_sync));
            check("R2 phase_a", int'(phase_a), int'(e_pa));
            check("R3 phase_b", int'(phase_b), int'(!e_pa));
            check("R3 mirror a", int'(phase_a_mir), int'(e_pa));
            check("R3 mirror b", int'(phase_b_mir), int'(!e_pa));
            check("R7 strobe", int'(pix_strobe), int'(e_stb));
            check("R6 ref_flag", int'(ref_flag), int'(e_ref));
            check("R9 line_done", int'(line_done), int'(e_done));
            if (t >= he && t < d) check("R5 pix_idx", int'(pix_idx), p);
            if (t == glitch_t) begin                  // R10 ignored request
                start = 1'b1;
                half_period = CNT_W'(he + 3);
                extra_pix = PIX_W'(x + 2);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 line_sync", int'(line_sync), 0);
        check("R11 phase_a", int'(phase_a), 0);
        check("R11 phase_b", int'(phase_b), 1);
        check("R11 strobe", int'(pix_strobe), 0);
        check("R11 line_done", int'(line_done), 0);
        rst_n = 1'b1;
        for (int h = 0; h <= 5; h++) begin
            for (int x = 0; x <= 3; x++) begin
                int he, d;
                he = (h < 2) ? 2 : h;
                d  = he + 2 * he * (ACT + ((x < 1) ? 1 : x));
                run_line(h, x, -1);
                run_line(h, x, he + 3);               // R10 mid-line request
                run_line(h, x, d - 1);                // R10 request with final edge
                run_line(h, x, d);                    // R10 request in done cycle
            end
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule